// File: doc/BRIEF.md
# Multi-Sector Address Stepper

This block keeps the per-sector address fields of a disk command register bank up to date while a multi-sector read or write runs. When a command starts, it copies the start sector, head, cylinder and sector count out of the register bank. Each time the transfer engine reports a finished sector, the stepper lowers the remaining count. It then moves the address fields so that they always name the sector that was just handled.

Two address views are supported. In the geometric view, sectors are numbered from 1 up to a programmed sectors-per-track value. The head field steps when the sector field wraps, and the cylinder steps when the head field wraps past a programmed last head. The cylinder is either a classic 10-bit number or a full 16-bit number. In the linear view, the same four fields are treated as one 28-bit block address and stepped by one. A sticky flag marks the moment the remaining count reaches zero. An abort freezes the fields on the last sector handled.

Top module: `sect_addr_stepper`

## Requirements
- R1: After reset, every address field and the remaining count read 0, the done flag `lastSector` is low, and finished-sector pulses have no effect until a command is loaded.
- R2: A `loadStart` pulse copies the start fields and start count to the outputs and clears `lastSector`. The first finished-sector pulse after a load leaves the address fields unchanged, because the start address is the sector just handled. Each later pulse advances the address by one sector.
- R3: Each accepted finished-sector pulse lowers the remaining count by one, modulo 256. A loaded count of 0 therefore stands for 256 sectors: after 255 pulses the count reads 1, and after 256 pulses it reads 0.
- R4: In the geometric view (`lbaMode` = 0), the sector field runs from 1 to `sectorsPerTrack`. When a sector at that limit is advanced, the sector field returns to 1 and the head field steps by one. Otherwise only the sector field steps.
- R5: When the sector wraps while the head field equals `lastHead` (the number of heads minus one, 4 bits), the head field returns to 0 and the cylinder steps by one. Carry always flows in the order sector, head, cylinder.
- R6: The cylinder is `{curCylHi, curCylLo}`. With `wideCyl` = 0, only its low 10 bits count, wrapping from 1023 to 0, and bits 7..2 of `curCylHi` keep their value. With `wideCyl` = 1, all 16 bits count, wrapping from 65535 to 0.
- R7: In the linear view (`lbaMode` = 1), the 28-bit value `{curHead, curCylHi, curCylLo, curSector}` (head nibble most significant) steps by one per advance, wrapping from all ones to zero. Geometry inputs are ignored.
- R8: `lastSector` rises on the clock edge where the count steps from 1 to 0 and stays high until the next load. Finished-sector pulses that arrive after that change neither the count nor the address fields.
- R9: An `abortCmd` pulse ends the command. Later finished-sector pulses are ignored, the fields keep naming the last sector handled, and `lastSector` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStart | input | 1 | Starts a command: copies the start fields |
| abortCmd | input | 1 | Ends the running command early |
| sectorDone | input | 1 | One-cycle pulse per finished sector |
| lbaMode | input | 1 | 1 = linear block address view, 0 = geometric view |
| wideCyl | input | 1 | 1 = 16-bit cylinder, 0 = 10-bit cylinder |
| sectorsPerTrack | input | 8 | Highest sector number on a track |
| lastHead | input | 4 | Highest head index (head count minus one) |
| startSector | input | 8 | Start sector field |
| startHead | input | 4 | Start head field |
| startCylLo | input | 8 | Start cylinder low byte |
| startCylHi | input | 8 | Start cylinder high byte |
| startCount | input | 8 | Sectors to transfer, 0 meaning 256 |
| curSector | output | 8 | Sector field of the last sector handled |
| curHead | output | 4 | Head field of the last sector handled |
| curCylLo | output | 8 | Cylinder low byte of the last sector handled |
| curCylHi | output | 8 | Cylinder high byte of the last sector handled |
| curCount | output | 8 | Sectors still to transfer |
| lastSector | output | 1 | Count has reached zero |

## Verification
The stepping logic is driven from starts that need no carry, starts that wrap only the sector field, and starts that ripple through head into cylinder. This separates a wrong carry order from a wrong wrap value. The cylinder is started at 0x3FF and at 0xFFFF in both widths, which shows whether the upper bits of the high byte are kept or counted. The linear view is started at values that carry through one byte and through all 28 bits. These cases expose byte-ordering mistakes that a plain increment would hide. Count-of-zero runs, single-sector commands, aborts and pulses after completion check that the count, the flag and the frozen fields stay coherent at the command edges.

// File: rtl/sect_addr_pkg.sv
package sect_addr_pkg;

  // Strobes from the control side to the address datapath.
  typedef struct packed {
    logic load;   // capture start fields
    logic step;   // advance address by one sector
  } addrStrobe_t;

endpackage

// File: rtl/sect_addr_ctrl.sv
module sect_addr_ctrl
  import sect_addr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStart,
  input  logic             abortCmd,
  input  logic             sectorDone,
  input  logic [CNT_W-1:0] startCount,
  output addrStrobe_t      strobe,
  output logic [CNT_W-1:0] count,
  output logic             lastFlag
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic active;
  logic begun;
  logic accept;

  assign accept = active && sectorDone && !loadStart && !abortCmd;

  always_comb begin
    strobe.load = loadStart;
    strobe.step = accept && begun;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      begun    <= 1'b0;
      count    <= '0;
      lastFlag <= 1'b0;
    end else if (loadStart) begin
      active   <= 1'b1;
      begun    <= 1'b0;
      count    <= startCount;
      lastFlag <= 1'b0;
    end else if (abortCmd) begin
      active   <= 1'b0;
    end else if (accept) begin
      count <= count - CNT_ONE;
      begun <= 1'b1;
      if (count == CNT_ONE) begin
        lastFlag <= 1'b1;
        active   <= 1'b0;
      end
    end
  end

  // R3: every accepted pulse lowers the count by exactly one
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> count == $past(count) - CNT_ONE);

  // R8: the done flag holds until a new load
  p_last_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lastFlag && !loadStart) |=> lastFlag);

  // R9: an idle stepper keeps its count
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !loadStart) |=> $stable(count));

  // R2: no address step happens in the cycle right after a load
  p_first_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadStart |=> !strobe.step);

endmodule

// File: rtl/sect_addr_path.sv
module sect_addr_path
  import sect_addr_pkg::*;
#(
  parameter int SECT_W    = 8,
  parameter int HEAD_W    = 4,
  parameter int CYLB_W    = 8,
  parameter int CLASSIC_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  addrStrobe_t       strobe,
  input  logic              lbaMode,
  input  logic              wideCyl,
  input  logic [SECT_W-1:0] sectorsPerTrack,
  input  logic [HEAD_W-1:0] lastHead,
  input  logic [SECT_W-1:0] startSector,
  input  logic [HEAD_W-1:0] startHead,
  input  logic [CYLB_W-1:0] startCylLo,
  input  logic [CYLB_W-1:0] startCylHi,
  output logic [SECT_W-1:0] sector,
  output logic [HEAD_W-1:0] head,
  output logic [CYLB_W-1:0] cylLo,
  output logic [CYLB_W-1:0] cylHi
);

  localparam int CYL_W = 2 * CYLB_W;
  localparam int LBA_W = HEAD_W + CYL_W + SECT_W;

  logic [CYL_W-1:0]  cylNow;
  logic [CYL_W-1:0]  cylWideNext;
  logic [CYL_W-1:0]  cylClassicNext;
  logic [CYL_W-1:0]  cylNext;
  logic [LBA_W-1:0]  lbaNow;
  logic [LBA_W-1:0]  lbaNext;
  logic [SECT_W-1:0] chsSector;
  logic [HEAD_W-1:0] chsHead;
  logic [CYL_W-1:0]  chsCyl;
  logic              sectWrap;
  logic              headWrap;

  assign cylNow      = {cylHi, cylLo};
  assign cylWideNext = cylNow + CYL_W'(1);

  // Classic cylinder: only the low CLASSIC_W bits count.
  generate
    if (CLASSIC_W < CYL_W) begin : g_classic_split
      logic [CLASSIC_W-1:0] lowPart;
      assign lowPart        = cylNow[CLASSIC_W-1:0] + CLASSIC_W'(1);
      assign cylClassicNext = {cylNow[CYL_W-1:CLASSIC_W], lowPart};
    end else begin : g_classic_full
      assign cylClassicNext = cylWideNext;
    end
  endgenerate

  assign cylNext = wideCyl ? cylWideNext : cylClassicNext;

  // Geometric carry chain: sector, then head, then cylinder.
  always_comb begin
    sectWrap  = (sector >= sectorsPerTrack);
    headWrap  = (head == lastHead);
    chsSector = sector + SECT_W'(1);
    chsHead   = head;
    chsCyl    = cylNow;
    if (sectWrap) begin
      chsSector = SECT_W'(1);
      if (headWrap) begin
        chsHead = '0;
        chsCyl  = cylNext;
      end else begin
        chsHead = head + HEAD_W'(1);
      end
    end
  end

  assign lbaNow  = {head, cylHi, cylLo, sector};
  assign lbaNext = lbaNow + LBA_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sector <= '0;
      head   <= '0;
      cylLo  <= '0;
      cylHi  <= '0;
    end else if (strobe.load) begin
      sector <= startSector;
      head   <= startHead;
      cylLo  <= startCylLo;
      cylHi  <= startCylHi;
    end else if (strobe.step) begin
      if (lbaMode) begin
        {head, cylHi, cylLo, sector} <= lbaNext;
      end else begin
        sector         <= chsSector;
        head           <= chsHead;
        {cylHi, cylLo} <= chsCyl;
      end
    end
  end

  // R4: below the track limit only the sector field moves
  p_sector_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && !lbaMode && sector != '0 && sector < sectorsPerTrack)
      |=> (sector == $past(sector) + SECT_W'(1)) && $stable(head) && $stable(cylLo));

  // R5: a sector wrap on the last head returns to head 0, sector 1
  p_head_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && !lbaMode && sector == sectorsPerTrack && head == lastHead)
      |=> (head == '0) && (sector == SECT_W'(1)));

  // R6: a classic cylinder leaves the upper bits of the high byte alone
  p_classic_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && !lbaMode && !wideCyl)
      |=> cylHi[CYLB_W-1:CLASSIC_W-CYLB_W] == $past(cylHi[CYLB_W-1:CLASSIC_W-CYLB_W]));

  // R7: the linear view moves the joined fields up by one
  p_lba_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && lbaMode)
      |=> {head, cylHi, cylLo, sector} == $past({head, cylHi, cylLo, sector}) + LBA_W'(1));

endmodule

// File: rtl/sect_addr_stepper.sv
module sect_addr_stepper
  import sect_addr_pkg::*;
#(
  parameter int SECT_W    = 8,
  parameter int HEAD_W    = 4,
  parameter int CYLB_W    = 8,
  parameter int CLASSIC_W = 10,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStart,
  input  logic              abortCmd,
  input  logic              sectorDone,
  input  logic              lbaMode,
  input  logic              wideCyl,
  input  logic [SECT_W-1:0] sectorsPerTrack,
  input  logic [HEAD_W-1:0] lastHead,
  input  logic [SECT_W-1:0] startSector,
  input  logic [HEAD_W-1:0] startHead,
  input  logic [CYLB_W-1:0] startCylLo,
  input  logic [CYLB_W-1:0] startCylHi,
  input  logic [CNT_W-1:0]  startCount,
  output logic [SECT_W-1:0] curSector,
  output logic [HEAD_W-1:0] curHead,
  output logic [CYLB_W-1:0] curCylLo,
  output logic [CYLB_W-1:0] curCylHi,
  output logic [CNT_W-1:0]  curCount,
  output logic              lastSector
);

  addrStrobe_t strobe;

  sect_addr_ctrl #(
    .CNT_W(CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .loadStart (loadStart),
    .abortCmd  (abortCmd),
    .sectorDone(sectorDone),
    .startCount(startCount),
    .strobe    (strobe),
    .count     (curCount),
    .lastFlag  (lastSector)
  );

  sect_addr_path #(
    .SECT_W   (SECT_W),
    .HEAD_W   (HEAD_W),
    .CYLB_W   (CYLB_W),
    .CLASSIC_W(CLASSIC_W)
  ) path_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .lbaMode        (lbaMode),
    .wideCyl        (wideCyl),
    .sectorsPerTrack(sectorsPerTrack),
    .lastHead       (lastHead),
    .startSector    (startSector),
    .startHead      (startHead),
    .startCylLo     (startCylLo),
    .startCylHi     (startCylHi),
    .sector         (curSector),
    .head           (curHead),
    .cylLo          (curCylLo),
    .cylHi          (curCylHi)
  );

endmodule

// File: tb/sect_addr_stepper_tb.sv
`timescale 1ns/1ps
module sect_addr_stepper_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadStart = 1'b0;
  logic       abortCmd = 1'b0;
  logic       sectorDone = 1'b0;
  logic       lbaMode = 1'b0;
  logic       wideCyl = 1'b0;
  logic [7:0] sectorsPerTrack = 8'd17;
  logic [3:0] lastHead = 4'd3;
  logic [7:0] startSector = '0;
  logic [3:0] startHead = '0;
  logic [7:0] startCylLo = '0;
  logic [7:0] startCylHi = '0;
  logic [7:0] startCount = '0;
  logic [7:0] curSector;
  logic [3:0] curHead;
  logic [7:0] curCylLo;
  logic [7:0] curCylHi;
  logic [7:0] curCount;
  logic       lastSector;

  int checkCount = 0;
  int failCount  = 0;

  always #2.5 clk = ~clk;

  sect_addr_stepper dut_i (
    .clk(clk), .rstN(rstN), .loadStart(loadStart), .abortCmd(abortCmd),
    .sectorDone(sectorDone), .lbaMode(lbaMode), .wideCyl(wideCyl),
    .sectorsPerTrack(sectorsPerTrack), .lastHead(lastHead),
    .startSector(startSector), .startHead(startHead),
    .startCylLo(startCylLo), .startCylHi(startCylHi), .startCount(startCount),
    .curSector(curSector), .curHead(curHead), .curCylLo(curCylLo),
    .curCylHi(curCylHi), .curCount(curCount), .lastSector(lastSector)
  );

  typedef struct packed {
    logic       lba;
    logic       wide;
    logic [7:0] spt;
    logic [3:0] lh;
    logic [7:0] s;
    logic [3:0] h;
    logic [7:0] cl;
    logic [7:0] ch;
    logic [7:0] cnt;
    logic [8:0] nd;
    logic [7:0] es;
    logic [3:0] eh;
    logic [7:0] ecl;
    logic [7:0] ech;
    logic [7:0] ecnt;
    logic       el;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    // R2 R3: plain run, no carry
    '{1'b0,1'b0,8'd17,4'd3, 8'd1,4'd0,8'h00,8'h00, 8'd3,9'd3,   8'd3,4'd0,8'h00,8'h00, 8'd0,1'b1},
    // R4: sector wraps into next head
    '{1'b0,1'b0,8'd17,4'd3, 8'd16,4'd0,8'h00,8'h00, 8'd3,9'd3,  8'd1,4'd1,8'h00,8'h00, 8'd0,1'b1},
    // R5: head wraps into cylinder
    '{1'b0,1'b0,8'd17,4'd3, 8'd17,4'd3,8'h05,8'h00, 8'd2,9'd2,  8'd1,4'd0,8'h06,8'h00, 8'd0,1'b1},
    // R6: low byte carries into high byte
    '{1'b0,1'b0,8'd17,4'd3, 8'd17,4'd3,8'hFF,8'h01, 8'd2,9'd2,  8'd1,4'd0,8'h00,8'h02, 8'd0,1'b1},
    // R6: classic wrap keeps upper bits of high byte
    '{1'b0,1'b0,8'd17,4'd3, 8'd17,4'd3,8'hFF,8'hFF, 8'd2,9'd2,  8'd1,4'd0,8'h00,8'hFC, 8'd0,1'b1},
    // R6: wide wrap clears all 16 bits
    '{1'b0,1'b1,8'd17,4'd3, 8'd17,4'd3,8'hFF,8'hFF, 8'd2,9'd2,  8'd1,4'd0,8'h00,8'h00, 8'd0,1'b1},
    // R7: linear carry through two bytes
    '{1'b1,1'b0,8'd17,4'd3, 8'hFF,4'd3,8'hFF,8'h12, 8'd2,9'd2,  8'h00,4'd3,8'h00,8'h13, 8'd0,1'b1},
    // R7: linear full 28-bit wrap
    '{1'b1,1'b0,8'd17,4'd3, 8'hFF,4'hF,8'hFF,8'hFF, 8'd2,9'd2,  8'h00,4'd0,8'h00,8'h00, 8'd0,1'b1},
    // R3: count 0 means 256
    '{1'b0,1'b0,8'd63,4'd15, 8'd1,4'd0,8'h00,8'h00, 8'd0,9'd5,  8'd5,4'd0,8'h00,8'h00, 8'hFB,1'b0},
    // R4 R5: small geometry, partial run
    '{1'b0,1'b0,8'd2,4'd1,  8'd1,4'd0,8'h00,8'h00, 8'd10,9'd4, 8'd2,4'd1,8'h00,8'h00, 8'd6,1'b0},
    // R2: single sector keeps start address
    '{1'b0,1'b0,8'd17,4'd3, 8'd9,4'd2,8'h07,8'h00, 8'd1,9'd1,   8'd9,4'd2,8'h07,8'h00, 8'd0,1'b1},
    // R7: linear step without carry
    '{1'b1,1'b0,8'd17,4'd3, 8'd5,4'd2,8'h03,8'h04, 8'd4,9'd3,   8'd7,4'd2,8'h03,8'h04, 8'd1,1'b0},
    // R6: wide cylinder crosses bit 10
    '{1'b0,1'b1,8'd17,4'd3, 8'd17,4'd3,8'hFF,8'h03, 8'd2,9'd2,  8'd1,4'd0,8'h00,8'h04, 8'd0,1'b1},
    // R6: classic cylinder wraps at bit 10
    '{1'b0,1'b0,8'd17,4'd3, 8'd17,4'd3,8'hFF,8'h03, 8'd2,9'd2,  8'd1,4'd0,8'h00,8'h00, 8'd0,1'b1}
  };

  task automatic checkVal(input string tag, input string what, input int actual, input int expected);
    checkCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, actual, expected);
    end
  endtask

  task automatic checkAll(input string tag, input int es, input int eh, input int ecl,
                          input int ech, input int ecnt, input int el);
    checkVal(tag, "sector", int'(curSector), es);
    checkVal(tag, "head",   int'(curHead),   eh);
    checkVal(tag, "cylLo",  int'(curCylLo),  ecl);
    checkVal(tag, "cylHi",  int'(curCylHi),  ech);
    checkVal(tag, "count",  int'(curCount),  ecnt);
    checkVal(tag, "last",   int'(lastSector), el);
  endtask

  task automatic loadCmd(input logic lba, input logic wide, input logic [7:0] spt,
                         input logic [3:0] lh, input logic [7:0] s, input logic [3:0] h,
                         input logic [7:0] cl, input logic [7:0] ch, input logic [7:0] cnt);
    @(negedge clk);
    lbaMode = lba; wideCyl = wide; sectorsPerTrack = spt; lastHead = lh;
    startSector = s; startHead = h; startCylLo = cl; startCylHi = ch; startCount = cnt;
    loadStart = 1'b1;
    @(negedge clk);
    loadStart = 1'b0;
  endtask

  task automatic pulseDone(input int n);
    for (int i = 0; i < n; i++) begin
      sectorDone = 1'b1;
      @(negedge clk);
    end
    sectorDone = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    #400000;
    failCount++;
    checkCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll("R1 reset", 0, 0, 0, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    pulseDone(3);
    @(negedge clk);
    checkAll("R1 pulses before load ignored", 0, 0, 0, 0, 0, 0);

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      loadCmd(VECS[v].lba, VECS[v].wide, VECS[v].spt, VECS[v].lh, VECS[v].s,
              VECS[v].h, VECS[v].cl, VECS[v].ch, VECS[v].cnt);
      pulseDone(int'(VECS[v].nd));
      @(negedge clk);
      checkAll($sformatf("vector %0d", v), int'(VECS[v].es), int'(VECS[v].eh),
               int'(VECS[v].ecl), int'(VECS[v].ech), int'(VECS[v].ecnt), int'(VECS[v].el));
    end

    // R2: load copies start fields and clears the flag
    loadCmd(1'b0, 1'b0, 8'd17, 4'd3, 8'd4, 4'd1, 8'h22, 8'h01, 8'd5);
    checkAll("R2 load copy", 4, 1, 'h22, 1, 5, 0);

    // R8: pulses after completion change nothing
    loadCmd(1'b0, 1'b0, 8'd17, 4'd3, 8'd1, 4'd0, 8'h00, 8'h00, 8'd2);
    pulseDone(2);
    @(negedge clk);
    checkAll("R8 completed", 2, 0, 0, 0, 0, 1);
    pulseDone(4);
    @(negedge clk);
    checkAll("R8 extra pulses ignored", 2, 0, 0, 0, 0, 1);

    // R9: abort freezes the last handled sector
    loadCmd(1'b0, 1'b0, 8'd17, 4'd3, 8'd10, 4'd0, 8'h00, 8'h00, 8'd5);
    pulseDone(2);
    abortCmd = 1'b1;
    @(negedge clk);
    abortCmd = 1'b0;
    pulseDone(3);
    @(negedge clk);
    checkAll("R9 abort freeze", 11, 0, 0, 0, 3, 0);

    // R3 R4 R5: full 256-sector command from count 0
    loadCmd(1'b0, 1'b0, 8'd63, 4'd15, 8'd1, 4'd0, 8'h00, 8'h00, 8'd0);
    pulseDone(255);
    @(negedge clk);
    checkAll("R3 after 255 of 256", 3, 4, 0, 0, 1, 0);
    pulseDone(1);
    @(negedge clk);
    checkAll("R3 after 256 of 256", 4, 4, 0, 0, 0, 1);

    // R2: reload while running restarts cleanly
    loadCmd(1'b0, 1'b0, 8'd17, 4'd3, 8'd3, 4'd0, 8'h00, 8'h00, 8'd6);
    pulseDone(2);
    loadCmd(1'b1, 1'b0, 8'd17, 4'd3, 8'd8, 4'd1, 8'h00, 8'h00, 8'd3);
    pulseDone(2);
    @(negedge clk);
    checkAll("R2 reload mid command", 9, 1, 0, 0, 1, 0);

    summary();
  end

endmodule